// File: doc/BRIEF.md
# Circular Return-Address Stack

This block keeps the return addresses of a small microcontroller core. It has a fixed number of slots, each wide enough for a full program address. The core's control logic raises a push strobe with the current program counter when it takes a call or an interrupt branch. It raises a pop strobe when it executes any of its return forms. The stack always presents the most recent entry on a registered output, so the return path can use it without waiting for a read.

The pointer is internal and software cannot reach it. It moves around a ring. Extra pushes go past the last slot and overwrite the oldest entries without any warning. Extra pops step backwards past slot zero and return whatever the slot they land on holds. The block raises no overflow or underflow indication.

Top module: `rstk_top`

## Requirements
- R1: The stack holds DEPTH (default 8) entries of ADDR_W (default 13) bits. Up to DEPTH pushed values come back in reverse order of pushing, one per pop.
- R2: A cycle with `push_i`=1 and `pop_i`=0 stores `push_addr_i`. From the next cycle on, `top_o` shows that value and the pointer has advanced by one slot.
- R3: A cycle with `pop_i`=1 and `push_i`=0 moves the pointer back one slot. From the next cycle on, `top_o` shows the entry that was below the old top.
- R4: Once DEPTH pushes have been made without pops, push number DEPTH+1 overwrites the slot that push number 1 wrote. Later pushes overwrite push 2, push 3 and so on. After DEPTH+1 pushes, DEPTH-1 pops reveal pushes DEPTH down to 2. The next pop reveals push DEPTH+1.
- R5: The pointer wraps in the pop direction too, and no flag is raised. After DEPTH pushes, DEPTH-1 pops reveal pushes DEPTH-1 down to 1. Pop number DEPTH returns the last value pushed, because that is the content of the slot it wraps onto.
- R6: A cycle with `push_i`=1 and `pop_i`=1 replaces the top entry with `push_addr_i` and leaves the pointer unchanged. From the next cycle on, `top_o` shows the new value. A following pop reveals the entry below, which is unchanged.
- R7: A cycle with neither strobe leaves `top_o` and the pointer unchanged.
- R8: Synchronous active-high `rst` returns the pointer to slot zero and makes `top_o` read zero. Stored entries keep undefined contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| push_i | input | 1 | Push strobe (call or interrupt entry) |
| pop_i | input | 1 | Pop strobe (any return form) |
| push_addr_i | input | ADDR_W | Address to push |
| top_o | output | ADDR_W | Current top entry, registered |

## Verification
The bench builds the stack with its default parameters, DEPTH=8 and ADDR_W=13. With these values, a run of nine pushes or eight pops is enough to wrap the three-bit pointer in either direction. That is what makes the overwrite order and the empty-stack pop checkable in a few dozen cycles. The 13-bit width lets the all-ones address 0x1FFF pass through a slot as a boundary value.

// File: rtl/rstk_pkg.sv
package rstk_pkg;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2,
    OP_SWAP = 2'd3
  } stk_op_e;

  function automatic stk_op_e decode_op(input logic push, input logic pop);
    case ({pop, push})
      2'b01:   return OP_PUSH;
      2'b10:   return OP_POP;
      2'b11:   return OP_SWAP;
      default: return OP_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/rstk_ring_ptr.sv
module rstk_ring_ptr
  import rstk_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  stk_op_e       op,
  output logic [PW-1:0] ptr_o,
  output logic [PW-1:0] below_o,
  output logic [PW-1:0] below2_o
);

  localparam bit POW2 = (DEPTH & (DEPTH - 1)) == 0;

  logic [PW-1:0] ptr_q;
  logic [PW-1:0] ptr_inc;
  logic [PW-1:0] ptr_dec;
  logic [PW-1:0] ptr_dec2;

  generate
    if (POW2) begin : g_pow2
      assign ptr_inc  = ptr_q + PW'(1);
      assign ptr_dec  = ptr_q - PW'(1);
      assign ptr_dec2 = ptr_q - PW'(2);
    end else begin : g_cmp
      assign ptr_inc  = (ptr_q == PW'(DEPTH - 1)) ? '0 : ptr_q + PW'(1);
      assign ptr_dec  = (ptr_q == '0) ? PW'(DEPTH - 1) : ptr_q - PW'(1);
      assign ptr_dec2 = (ptr_dec == '0) ? PW'(DEPTH - 1) : ptr_dec - PW'(1);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else begin
      case (op)
        OP_PUSH: ptr_q <= ptr_inc;
        OP_POP:  ptr_q <= ptr_dec;
        default: ptr_q <= ptr_q;
      endcase
    end
  end

  assign ptr_o    = ptr_q;
  assign below_o  = ptr_dec;
  assign below2_o = ptr_dec2;

  // R2: after a push the slot just written sits directly below the pointer
  p_push_step_r2: assert property (@(posedge clk) disable iff (rst)
    op == OP_PUSH |=> below_o == $past(ptr_o));
  // R3: a pop lands the pointer on the old top slot
  p_pop_step_r3: assert property (@(posedge clk) disable iff (rst)
    op == OP_POP |=> ptr_o == $past(below_o));
  // R6: a combined push and pop keeps the pointer
  p_swap_hold_r6: assert property (@(posedge clk) disable iff (rst)
    op == OP_SWAP |=> $stable(ptr_o));
  // R7: idle keeps the pointer
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
    op == OP_IDLE |=> $stable(ptr_o));
  // R8: reset returns to slot zero
  p_reset_zero_r8: assert property (@(posedge clk)
    rst |=> ptr_o == '0);

endmodule

// File: rtl/rstk_ram.sv
module rstk_ram #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 13,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [PW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [PW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [WIDTH-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata_q <= mem[raddr];
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/rstk_top.sv
module rstk_top
  import rstk_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 13,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [ADDR_W-1:0] push_addr_i,
  output logic [ADDR_W-1:0] top_o
);

  stk_op_e          op;
  logic [PW-1:0]     ptr;
  logic [PW-1:0]     below;
  logic [PW-1:0]     below2;
  logic              wr_en;
  logic [PW-1:0]     wr_slot;
  logic              rd_en;
  logic [ADDR_W-1:0] rd_data;
  logic [ADDR_W-1:0] fwd_q;
  logic              use_fwd_q;

  assign op      = decode_op(push_i, pop_i);
  assign wr_en   = (op == OP_PUSH) || (op == OP_SWAP);
  assign wr_slot = (op == OP_SWAP) ? below : ptr;
  assign rd_en   = (op == OP_POP);

  rstk_ring_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk      (clk),
    .rst      (rst),
    .op       (op),
    .ptr_o    (ptr),
    .below_o  (below),
    .below2_o (below2)
  );

  rstk_ram #(.DEPTH(DEPTH), .WIDTH(ADDR_W)) u_ram (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_slot),
    .wdata (push_addr_i),
    .re    (rd_en),
    .raddr (below2),
    .rdata (rd_data)
  );

  // A written value is forwarded from its own register; a pop takes the
  // synchronous memory read of the slot that becomes the new top.
  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_q     <= '0;
      use_fwd_q <= 1'b1;
    end else if (wr_en) begin
      fwd_q     <= push_addr_i;
      use_fwd_q <= 1'b1;
    end else if (rd_en) begin
      use_fwd_q <= 1'b0;
    end
  end

  assign top_o = use_fwd_q ? fwd_q : rd_data;

  // R2 and R6: any push makes its address the visible top
  p_push_top_r2: assert property (@(posedge clk) disable iff (rst)
    push_i |=> top_o == $past(push_addr_i));
  // R7: no strobe, no change on the output
  p_idle_top_r7: assert property (@(posedge clk) disable iff (rst)
    !push_i && !pop_i |=> $stable(top_o));
  // R8: reset shows zero on the output
  p_reset_top_r8: assert property (@(posedge clk)
    rst |=> top_o == '0);

endmodule

// File: tb/test_rstk_top.sv
module test_rstk_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 13;
  localparam int DEPTH = 8;

  typedef struct packed {
    logic          push;
    logic          pop;
    logic [AW-1:0] addr;
    logic [AW-1:0] exp;
    logic [3:0]    req;
  } vec_t;

  // Walked from reset state (pointer at slot zero)
  localparam vec_t VEC [12] = '{
    '{1'b1, 1'b0, 13'h0100, 13'h0100, 4'd2},  // R2 push
    '{1'b1, 1'b0, 13'h01A5, 13'h01A5, 4'd2},  // R2
    '{1'b1, 1'b0, 13'h00FF, 13'h00FF, 4'd2},  // R2
    '{1'b0, 1'b0, 13'h1555, 13'h00FF, 4'd7},  // R7 idle ignores data
    '{1'b0, 1'b1, 13'h0AAA, 13'h01A5, 4'd3},  // R3 pop
    '{1'b1, 1'b1, 13'h1234, 13'h1234, 4'd6},  // R6 replace top
    '{1'b0, 1'b1, 13'h0000, 13'h0100, 4'd6},  // R6 entry below intact
    '{1'b1, 1'b0, 13'h1FFF, 13'h1FFF, 4'd2},  // R2 all ones
    '{1'b1, 1'b0, 13'h0000, 13'h0000, 4'd2},  // R2 all zeros
    '{1'b0, 1'b1, 13'h0000, 13'h1FFF, 4'd3},  // R3
    '{1'b0, 1'b1, 13'h0000, 13'h0100, 4'd3},  // R3
    '{1'b0, 1'b0, 13'h0000, 13'h0100, 4'd7}   // R7
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          push_i = 1'b0;
  logic          pop_i = 1'b0;
  logic [AW-1:0] push_addr_i = '0;
  logic [AW-1:0] top_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rstk_top #(.DEPTH(DEPTH), .ADDR_W(AW)) i_rstk_top (
    .clk         (clk),
    .rst         (rst),
    .push_i      (push_i),
    .pop_i       (pop_i),
    .push_addr_i (push_addr_i),
    .top_o       (top_o)
  );

  task automatic check(input int req, input logic [AW-1:0] exp, input string what);
    checks++;
    if (top_o !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, top_o, exp);
    end
  endtask

  // Drive one cycle at the falling edge, sample after the next rising edge
  task automatic op(input logic p, input logic q, input logic [AW-1:0] a);
    push_i = p;
    pop_i = q;
    push_addr_i = a;
    @(posedge clk);
    @(negedge clk);
    push_i = 1'b0;
    pop_i = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  function automatic logic [AW-1:0] val_a(input int i);
    return AW'(16'h00A0 + i * 16'h0111);
  endfunction

  function automatic logic [AW-1:0] val_b(input int i);
    return AW'(16'h1C00 + i * 16'h0003);
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL R0 watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    check(8, '0, "reset top");  // R8

    for (int i = 0; i < 12; i++) begin
      op(VEC[i].push, VEC[i].pop, VEC[i].addr);
      check(int'(VEC[i].req), VEC[i].exp, $sformatf("vector %0d", i));
    end

    // R4 and R1: nine pushes, then pops reveal the overwrite order
    do_reset();
    for (int i = 0; i <= DEPTH; i++) begin
      op(1'b1, 1'b0, val_a(i));
      check(1, val_a(i), "push sequence");
    end
    for (int k = 1; k < DEPTH; k++) begin
      op(1'b0, 1'b1, '0);
      check(4, val_a(DEPTH - k), "pop after overwrite");
    end
    op(1'b0, 1'b1, '0);
    check(4, val_a(DEPTH), "slot zero holds ninth push");

    // R5: eight pushes, eight pops, the last wraps past empty
    do_reset();
    for (int i = 0; i < DEPTH; i++) op(1'b1, 1'b0, val_b(i));
    check(5, val_b(DEPTH - 1), "full top");
    for (int k = 1; k < DEPTH; k++) begin
      op(1'b0, 1'b1, '0);
      check(5, val_b(DEPTH - 1 - k), "pop down");
    end
    op(1'b0, 1'b1, '0);
    check(5, val_b(DEPTH - 1), "pop past empty wraps");

    // R8: reset in the middle of use restarts the pointer
    op(1'b1, 1'b0, 13'h0333);
    op(1'b1, 1'b0, 13'h0444);
    do_reset();
    check(8, '0, "reset mid use");
    op(1'b1, 1'b0, 13'h0777);
    op(1'b1, 1'b0, 13'h0888);
    op(1'b0, 1'b1, '0);
    check(8, 13'h0777, "push after reset");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule